// File: doc/BRIEF.md
# Network controller control/status register

This block is the host-facing register file and interrupt logic of a DMA Ethernet controller. A 16-bit word-addressed bus slave port exposes the station address bytes, staging registers for the start addresses of the receive and transmit descriptor lists, an interrupt vector register and a control/status word. Descriptor engines and the line interface report completions, memory errors, end-of-list and line state through single-cycle event inputs. The block drives one interrupt request line, the mode controls, a device reset level and one launch strobe per descriptor list.

Software normally sets the receiver enable, interrupt enable and internal loopback bits in one write. It loads a list address low word first, then the high word, and that second write launches the list. Pending completion requests are cleared by writing back the status word just read, because both request bits clear when a one is written to them. A self-reset bit forces the device idle until software writes it back to zero.

Top module: `nic_csr`

## Requirements
- R1: After rst_ni deasserts, the status word (offset 9) reads 0x0030 plus the line bits of R3, the vector reads 0, irq_o is low and all mode outputs are low.
- R2: Reads at offsets 0 to 5 return station address byte k (bits 8k+7:8k of station_addr_i) in bits 7:0 with bits 15:8 zero. Offsets 6, 7 and 10 to 15 read zero.
- R3: Status bits 0 (receive enable), 3 (boot select), 6 (interrupt enable), 8 (internal loopback), 9 (external loopback) and 10 (sanity timer) read back as written and drive rx_en_o, boot_sel_o, irq enable, int_loop_o, ext_loop_o and sanity_en_o. Bits 11 and 14 read zero. Writes to bits 2, 4, 5, 12 and 13 are ignored. Bit 12 mirrors fuse_ok_i and bit 13 mirrors carrier_i.
- R4: Bit 15 is set by rx_done_i and bit 7 by tx_done_i. Each clears when a one is written to it, and writing a zero leaves it unchanged. A set event in the same cycle as a clearing write leaves the bit set.
- R5: Bit 2 is set by nxm_err_i. Status writes do not clear it; only the self-reset does.
- R6: irq_o is high exactly when bit 6 is set and at least one of bits 15, 7 or 2 is set.
- R7: Receive list address words are at offsets 4 (low) and 5 (high), and transmit list address words at 6 and 7. A low-word write launches nothing. A high-word write raises the list's start strobe for one cycle, starting the cycle after the write, and clears that list's invalid bit (5 receive, 4 transmit). The address output is {high word bits LIST_AW-17:0, low word}.
- R8: A list's invalid bit is set by its end-of-list event (rx_eol_i, tx_eol_i). A launch in the same cycle as the event leaves it clear.
- R9: Writing bit 1 = 1 takes effect in the cycle after the write. Bits 0, 3, 6, 8, 9, 10, 15, 7 and 2 clear, both invalid bits set and dev_reset_o rises. While bit 1 is set, events are ignored, high-word writes launch nothing and a status write changes only bit 1. Writing bit 1 = 0 releases the reset.
- R10: Offset 8 is a 16-bit read/write vector register, driven on vector_o and untouched by the self-reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word offset of the access |
| wr_i | input | 1 | Write strobe, one word per cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| station_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| rx_done_i | input | 1 | Receive completion event |
| tx_done_i | input | 1 | Transmit completion event |
| nxm_err_i | input | 1 | Nonexistent-memory error event |
| rx_eol_i | input | 1 | Receive engine reached end of list |
| tx_eol_i | input | 1 | Transmit engine reached end of list |
| carrier_i | input | 1 | Line carrier present |
| fuse_ok_i | input | 1 | Bus power fuse intact |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 16 | Interrupt vector register |
| rx_en_o | output | 1 | Receiver enable |
| boot_sel_o | output | 1 | Boot/diagnostic select |
| int_loop_o | output | 1 | Internal loopback |
| ext_loop_o | output | 1 | External loopback |
| sanity_en_o | output | 1 | Sanity timer enable |
| dev_reset_o | output | 1 | Self-reset level, aborts both engines |
| rx_start_o | output | 1 | Receive list launch strobe |
| rx_list_addr_o | output | LIST_AW | Receive list start address |
| tx_start_o | output | 1 | Transmit list launch strobe |
| tx_list_addr_o | output | LIST_AW | Transmit list start address |

## Verification
Two collisions matter. A completion event can arrive in the same cycle as the software write that clears its request bit, and an end-of-list event can arrive in the same cycle as the high-word write that relaunches the list. The bench drives the event pulse and the bus write on the same negative edge so that both reach one clock edge. It then reads the status word: the request bit must still be set, the invalid bit must be clear and the start strobe must be seen.

// File: rtl/nic_csr_pkg.sv
`timescale 1ns/1ps
package nic_csr_pkg;
  localparam int unsigned CSR_W = 16;

  localparam logic [3:0] OFF_RXL = 4'd4;
  localparam logic [3:0] OFF_RXH = 4'd5;
  localparam logic [3:0] OFF_TXL = 4'd6;
  localparam logic [3:0] OFF_TXH = 4'd7;
  localparam logic [3:0] OFF_VEC = 4'd8;
  localparam logic [3:0] OFF_CSR = 4'd9;
  localparam int unsigned N_SA_BYTES = 6;

  localparam int unsigned B_RXEN   = 0;
  localparam int unsigned B_SRST   = 1;
  localparam int unsigned B_NXM    = 2;
  localparam int unsigned B_BOOT   = 3;
  localparam int unsigned B_TXINV  = 4;
  localparam int unsigned B_RXINV  = 5;
  localparam int unsigned B_IE     = 6;
  localparam int unsigned B_TXREQ  = 7;
  localparam int unsigned B_ILOOP  = 8;
  localparam int unsigned B_ELOOP  = 9;
  localparam int unsigned B_SANITY = 10;
  localparam int unsigned B_FUSE   = 12;
  localparam int unsigned B_CARR   = 13;
  localparam int unsigned B_RXREQ  = 15;

  typedef struct packed {
    logic sanity;
    logic eloop;
    logic iloop;
    logic ie;
    logic boot;
    logic rxen;
  } ctrl_t;
endpackage

// File: rtl/nic_csr_decode.sv
`timescale 1ns/1ps
module nic_csr_decode
  import nic_csr_pkg::*;
(
  input  logic [3:0] addr_i,
  input  logic       wr_i,
  output logic       we_rxl_o,
  output logic       we_rxh_o,
  output logic       we_txl_o,
  output logic       we_txh_o,
  output logic       we_vec_o,
  output logic       we_csr_o
);
  always_comb begin
    we_rxl_o = wr_i && (addr_i == OFF_RXL);
    we_rxh_o = wr_i && (addr_i == OFF_RXH);
    we_txl_o = wr_i && (addr_i == OFF_TXL);
    we_txh_o = wr_i && (addr_i == OFF_TXH);
    we_vec_o = wr_i && (addr_i == OFF_VEC);
    we_csr_o = wr_i && (addr_i == OFF_CSR);
  end
endmodule

// File: rtl/nic_list_ptr.sv
`timescale 1ns/1ps
module nic_list_ptr #(
  parameter int unsigned LIST_AW = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dev_reset_i,
  input  logic               we_lo_i,
  input  logic               we_hi_i,
  input  logic [15:0]        wdata_i,
  input  logic               eol_i,
  output logic               start_o,
  output logic [LIST_AW-1:0] addr_o,
  output logic               invalid_o
);
  localparam int unsigned HI_W = LIST_AW - 16;

  logic [15:0]     lo_q;
  logic [HI_W-1:0] hi_q;
  logic            start_q, inv_q;
  logic            launch;

  assign launch = we_hi_i && !dev_reset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      start_q <= 1'b0;
      inv_q   <= 1'b1;
    end else begin
      if (we_lo_i) lo_q <= wdata_i;
      if (we_hi_i) hi_q <= wdata_i[HI_W-1:0];
      start_q <= launch;
      if (dev_reset_i)  inv_q <= 1'b1;
      else if (launch)  inv_q <= 1'b0;  // launch wins over end-of-list
      else if (eol_i)   inv_q <= 1'b1;
    end
  end

  assign start_o   = start_q;
  assign addr_o    = {hi_q, lo_q};
  assign invalid_o = inv_q;

  AST_ABORT_SETS_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_reset_i |=> (invalid_o && !start_o)); // R9
  AST_LAUNCH_CLEARS_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !dev_reset_i) |=> (start_o && !invalid_o)); // R7
  AST_LO_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_hi_i) |=> !start_o); // R7
  AST_EOL_SETS_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_i && !we_hi_i) |=> invalid_o); // R8
endmodule

// File: rtl/nic_csr_core.sv
`timescale 1ns/1ps
module nic_csr_core
  import nic_csr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_csr_i,
  input  logic [15:0] wdata_i,
  input  logic        rx_done_i,
  input  logic        tx_done_i,
  input  logic        nxm_err_i,
  output ctrl_t       ctrl_o,
  output logic        srst_o,
  output logic        srst_d_o,
  output logic        rx_req_o,
  output logic        tx_req_o,
  output logic        nxm_o,
  output logic        irq_o
);
  ctrl_t ctrl_q;
  logic  srst_q, rx_req_q, tx_req_q, nxm_q;
  logic  srst_d;

  assign srst_d = we_csr_i ? wdata_i[B_SRST] : srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      srst_q   <= 1'b0;
      rx_req_q <= 1'b0;
      tx_req_q <= 1'b0;
      nxm_q    <= 1'b0;
    end else begin
      srst_q <= srst_d;
      if (srst_d) begin
        ctrl_q   <= '0;
        rx_req_q <= 1'b0;
        tx_req_q <= 1'b0;
        nxm_q    <= 1'b0;
      end else begin
        if (we_csr_i && !srst_q) begin
          ctrl_q.rxen   <= wdata_i[B_RXEN];
          ctrl_q.boot   <= wdata_i[B_BOOT];
          ctrl_q.ie     <= wdata_i[B_IE];
          ctrl_q.iloop  <= wdata_i[B_ILOOP];
          ctrl_q.eloop  <= wdata_i[B_ELOOP];
          ctrl_q.sanity <= wdata_i[B_SANITY];
        end
        // set wins over write-one-to-clear
        rx_req_q <= rx_done_i || (rx_req_q && !(we_csr_i && wdata_i[B_RXREQ]));
        tx_req_q <= tx_done_i || (tx_req_q && !(we_csr_i && wdata_i[B_TXREQ]));
        nxm_q    <= nxm_q || nxm_err_i;
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign srst_o   = srst_q;
  assign srst_d_o = srst_d;
  assign rx_req_o = rx_req_q;
  assign tx_req_o = tx_req_q;
  assign nxm_o    = nxm_q;
  assign irq_o    = ctrl_q.ie && (rx_req_q || tx_req_q || nxm_q);

  AST_RXREQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !srst_d) |=> rx_req_o); // R4
  AST_TXREQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !srst_d) |=> tx_req_o); // R4
  AST_RXREQ_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_csr_i && wdata_i[B_RXREQ] && !rx_done_i) |=> !rx_req_o); // R4
  AST_NXM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxm_o && !srst_d) |=> nxm_o); // R5
  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_d |=> (!rx_req_o && !tx_req_o && !nxm_o && ctrl_o == '0 && srst_o)); // R9
endmodule

// File: rtl/nic_csr.sv
`timescale 1ns/1ps
module nic_csr
  import nic_csr_pkg::*;
#(
  parameter int unsigned LIST_AW = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         addr_i,
  input  logic               wr_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  input  logic [47:0]        station_addr_i,
  input  logic               rx_done_i,
  input  logic               tx_done_i,
  input  logic               nxm_err_i,
  input  logic               rx_eol_i,
  input  logic               tx_eol_i,
  input  logic               carrier_i,
  input  logic               fuse_ok_i,
  output logic               irq_o,
  output logic [15:0]        vector_o,
  output logic               rx_en_o,
  output logic               boot_sel_o,
  output logic               int_loop_o,
  output logic               ext_loop_o,
  output logic               sanity_en_o,
  output logic               dev_reset_o,
  output logic               rx_start_o,
  output logic [LIST_AW-1:0] rx_list_addr_o,
  output logic               tx_start_o,
  output logic [LIST_AW-1:0] tx_list_addr_o
);
  logic  we_rxl, we_rxh, we_txl, we_txh, we_vec, we_csr;
  ctrl_t ctrl;
  logic  srst_q, srst_d, rx_req, tx_req, nxm;
  logic  rx_inv, tx_inv;
  logic  ev_rx_done, ev_tx_done, ev_nxm;
  logic [15:0] vec_q, csr_word;
  logic [7:0]  sa_byte [N_SA_BYTES];

  nic_csr_decode u_dec (
    .addr_i(addr_i), .wr_i(wr_i),
    .we_rxl_o(we_rxl), .we_rxh_o(we_rxh), .we_txl_o(we_txl),
    .we_txh_o(we_txh), .we_vec_o(we_vec), .we_csr_o(we_csr)
  );

  // events ignored while held in self-reset
  assign ev_rx_done = rx_done_i && !srst_q;
  assign ev_tx_done = tx_done_i && !srst_q;
  assign ev_nxm     = nxm_err_i && !srst_q;

  nic_csr_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_csr_i(we_csr), .wdata_i(wdata_i),
    .rx_done_i(ev_rx_done), .tx_done_i(ev_tx_done), .nxm_err_i(ev_nxm),
    .ctrl_o(ctrl), .srst_o(srst_q), .srst_d_o(srst_d),
    .rx_req_o(rx_req), .tx_req_o(tx_req), .nxm_o(nxm), .irq_o(irq_o)
  );

  nic_list_ptr #(.LIST_AW(LIST_AW)) u_rx_list (
    .clk_i(clk_i), .rst_ni(rst_ni), .dev_reset_i(srst_d),
    .we_lo_i(we_rxl), .we_hi_i(we_rxh), .wdata_i(wdata_i), .eol_i(rx_eol_i),
    .start_o(rx_start_o), .addr_o(rx_list_addr_o), .invalid_o(rx_inv)
  );

  nic_list_ptr #(.LIST_AW(LIST_AW)) u_tx_list (
    .clk_i(clk_i), .rst_ni(rst_ni), .dev_reset_i(srst_d),
    .we_lo_i(we_txl), .we_hi_i(we_txh), .wdata_i(wdata_i), .eol_i(tx_eol_i),
    .start_o(tx_start_o), .addr_o(tx_list_addr_o), .invalid_o(tx_inv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (we_vec) vec_q <= wdata_i;
  end

  for (genvar k = 0; k < N_SA_BYTES; k++) begin : g_sa
    assign sa_byte[k] = station_addr_i[8*k +: 8];
  end

  always_comb begin
    csr_word           = '0;
    csr_word[B_RXEN]   = ctrl.rxen;
    csr_word[B_SRST]   = srst_q;
    csr_word[B_NXM]    = nxm;
    csr_word[B_BOOT]   = ctrl.boot;
    csr_word[B_TXINV]  = tx_inv;
    csr_word[B_RXINV]  = rx_inv;
    csr_word[B_IE]     = ctrl.ie;
    csr_word[B_TXREQ]  = tx_req;
    csr_word[B_ILOOP]  = ctrl.iloop;
    csr_word[B_ELOOP]  = ctrl.eloop;
    csr_word[B_SANITY] = ctrl.sanity;
    csr_word[B_FUSE]   = fuse_ok_i;
    csr_word[B_CARR]   = carrier_i;
    csr_word[B_RXREQ]  = rx_req;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < 4'(N_SA_BYTES))  rdata_o = {8'h00, sa_byte[addr_i[2:0]]};
    else if (addr_i == OFF_VEC)   rdata_o = vec_q;
    else if (addr_i == OFF_CSR)   rdata_o = csr_word;
  end

  assign vector_o    = vec_q;
  assign rx_en_o     = ctrl.rxen;
  assign boot_sel_o  = ctrl.boot;
  assign int_loop_o  = ctrl.iloop;
  assign ext_loop_o  = ctrl.eloop;
  assign sanity_en_o = ctrl.sanity;
  assign dev_reset_o = srst_q;

  AST_NO_LAUNCH_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_reset_o |-> (!rx_start_o && !tx_start_o)); // R9
  AST_VEC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_vec |=> $stable(vector_o)); // R10
  AST_EVENT_IGNORED_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_reset_o && $past(dev_reset_o)) |-> !irq_o); // R9
endmodule

// File: tb/tb_nic_csr.sv
`timescale 1ns/1ps
module tb_nic_csr;
  localparam int unsigned LIST_AW = 22;
  localparam logic [47:0] SA = 48'h0A1B2C3D4E5F;
  localparam logic [15:0] RW_MASK = 16'h0749;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic wr = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic rx_done = 0, tx_done = 0, nxm_err = 0, rx_eol = 0, tx_eol = 0;
  logic carrier = 0, fuse_ok = 1;
  logic irq, rx_en, boot_sel, int_loop, ext_loop, sanity_en, dev_reset;
  logic rx_start, tx_start;
  logic [15:0] vector;
  logic [LIST_AW-1:0] rx_addr, tx_addr;

  int n_chk = 0, n_fail = 0;
  logic got_rx_start, got_tx_start;

  always #2 clk = ~clk;

  nic_csr #(.LIST_AW(LIST_AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .station_addr_i(SA), .rx_done_i(rx_done), .tx_done_i(tx_done),
    .nxm_err_i(nxm_err), .rx_eol_i(rx_eol), .tx_eol_i(tx_eol), .carrier_i(carrier),
    .fuse_ok_i(fuse_ok), .irq_o(irq), .vector_o(vector), .rx_en_o(rx_en),
    .boot_sel_o(boot_sel), .int_loop_o(int_loop), .ext_loop_o(ext_loop),
    .sanity_en_o(sanity_en), .dev_reset_o(dev_reset), .rx_start_o(rx_start),
    .rx_list_addr_o(rx_addr), .tx_start_o(tx_start), .tx_list_addr_o(tx_addr)
  );

  function automatic logic [15:0] line_bits();
    return (16'(fuse_ok) << 12) | (16'(carrier) << 13);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive write plus optional events on one edge; capture start strobes after it
  task automatic wr_ev(input logic [3:0] a, input logic [15:0] d,
                       input logic rd, input logic td, input logic re, input logic te);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    rx_done = rd; tx_done = td; rx_eol = re; tx_eol = te;
    @(negedge clk);
    wr = 1'b0; rx_done = 0; tx_done = 0; rx_eol = 0; tx_eol = 0;
    got_rx_start = rx_start; got_tx_start = tx_start;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    wr_ev(a, d, 0, 0, 0, 0);
  endtask

  task automatic pulse(input logic rd, input logic td, input logic nx,
                       input logic re, input logic te);
    @(negedge clk);
    rx_done = rd; tx_done = td; nxm_err = nx; rx_eol = re; tx_eol = te;
    @(negedge clk);
    rx_done = 0; tx_done = 0; nxm_err = 0; rx_eol = 0; tx_eol = 0;
    got_rx_start = rx_start; got_tx_start = tx_start;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  initial begin
    #(4.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(4'd9, v); chk("R1 csr", v, 16'h0030 | line_bits());
    rd_reg(4'd8, v); chk("R1 vector", v, 16'h0000);
    chk("R1 irq/modes", {irq, rx_en, boot_sel, int_loop, ext_loop, sanity_en, dev_reset}, 0);

    // R2 station address sweep, all offsets except 8/9
    for (int k = 0; k < 16; k++) begin
      if (k == 8 || k == 9) continue;
      rd_reg(4'(k), v);
      e = (k < 6) ? {8'h00, SA[8*k +: 8]} : 16'h0000;
      chk("R2 station/zero read", v, e);
    end

    // R3 one-hot write sweep over the status word (bit 1 is the self-reset)
    for (int b = 0; b < 16; b++) begin
      if (b == 1) continue;
      wr_reg(4'd9, 16'(1) << b);
      rd_reg(4'd9, v);
      chk("R3 rw/ro/reserved bit", v, ((16'(1) << b) & RW_MASK) | 16'h0030 | line_bits());
      chk("R3 mode outputs", {sanity_en, ext_loop, int_loop, boot_sel, rx_en},
          {b == 10, b == 9, b == 8, b == 3, b == 0});
    end
    // R3 combined enable write and all-ones write
    wr_reg(4'd9, 16'h0141);
    rd_reg(4'd9, v); chk("R3 rx+ie+iloop together", v, 16'h0141 | 16'h0030 | line_bits());
    wr_reg(4'd9, 16'hFFFD);
    rd_reg(4'd9, v); chk("R3 all-ones masked", v, RW_MASK | 16'h0030 | line_bits());
    wr_reg(4'd9, 16'h0000);
    for (int c = 0; c < 4; c++) begin
      fuse_ok = c[0]; carrier = c[1];
      rd_reg(4'd9, v); chk("R3 line bits", v, 16'h0030 | line_bits());
    end
    fuse_ok = 1; carrier = 0;

    // R10 vector
    wr_reg(4'd8, 16'hA5C3);
    rd_reg(4'd8, v); chk("R10 vector rw", v, 16'hA5C3);
    chk("R10 vector_o", vector, 16'hA5C3);

    // R4 R5 R6 sweep over interrupt enable and event combinations
    for (int ie = 0; ie < 2; ie++) begin
      for (int m = 0; m < 8; m++) begin
        wr_reg(4'd9, 16'h0002);
        wr_reg(4'd9, 16'h0000);
        if (ie != 0) wr_reg(4'd9, 16'h0040);
        pulse(m[0], m[1], m[2], 0, 0);
        rd_reg(4'd9, v);
        e = (16'(ie) << 6) | (16'(m[0]) << 15) | (16'(m[1]) << 7) | (16'(m[2]) << 2)
            | 16'h0030 | line_bits();
        chk("R4 R5 event bits", v, e);
        chk("R6 irq", irq, (ie != 0) && (m != 0));
        // write back what was read: requests clear, nxm stays
        wr_reg(4'd9, v);
        rd_reg(4'd9, v);
        e = (16'(ie) << 6) | (16'(m[2]) << 2) | 16'h0030 | line_bits();
        chk("R4 R5 write-back clear", v, e);
        chk("R6 irq after clear", irq, (ie != 0) && m[2]);
      end
    end

    // R4 writing zero to the request bits does not clear them
    wr_reg(4'd9, 16'h0002); wr_reg(4'd9, 16'h0040);
    pulse(1, 1, 0, 0, 0);
    wr_reg(4'd9, 16'h0040);
    rd_reg(4'd9, v); chk("R4 zero write keeps requests", v & 16'h8080, 16'h8080);

    // R4 set event in the same cycle as the clearing write
    wr_ev(4'd9, 16'h8080, 1, 0, 0, 0);
    rd_reg(4'd9, v); chk("R4 rx set beats clear", v & 16'h8080, 16'h8000);
    wr_ev(4'd9, 16'h8080, 0, 1, 0, 0);
    rd_reg(4'd9, v); chk("R4 tx set beats clear", v & 16'h8080, 16'h0080);
    wr_reg(4'd9, 16'h0080);

    // R7 list launch
    wr_reg(4'd4, 16'h1234);
    chk("R7 low write no launch", got_rx_start, 0);
    rd_reg(4'd9, v); chk("R7 rx still invalid", v[5], 1);
    wr_reg(4'd5, 16'h002A);
    chk("R7 rx launch strobe", got_rx_start, 1);
    chk("R7 rx address", rx_addr, 22'h2A1234);
    rd_reg(4'd9, v); chk("R7 rx invalid cleared", v[5:4], 2'b01);
    @(negedge clk); chk("R7 strobe one cycle", rx_start, 0);
    wr_reg(4'd6, 16'hBEEF);
    chk("R7 tx low no launch", got_tx_start, 0);
    wr_reg(4'd7, 16'hFF15);
    chk("R7 tx launch strobe", got_tx_start, 1);
    chk("R7 tx address", tx_addr, 22'h15BEEF);
    rd_reg(4'd9, v); chk("R7 tx invalid cleared", v[5:4], 2'b00);

    // R8 end-of-list and collision with relaunch
    pulse(0, 0, 0, 1, 0);
    rd_reg(4'd9, v); chk("R8 rx eol sets invalid", v[5:4], 2'b10);
    pulse(0, 0, 0, 0, 1);
    rd_reg(4'd9, v); chk("R8 tx eol sets invalid", v[5:4], 2'b11);
    wr_ev(4'd5, 16'h0001, 0, 0, 1, 0);
    chk("R8 launch with eol strobe", got_rx_start, 1);
    rd_reg(4'd9, v); chk("R8 launch beats eol", v[5], 0);

    // R9 self-reset
    wr_reg(4'd9, 16'h0749);
    pulse(1, 1, 1, 0, 0);
    wr_reg(4'd9, 16'h0002);
    chk("R9 dev_reset_o", dev_reset, 1);
    rd_reg(4'd9, v); chk("R9 csr in reset", v, 16'h0032 | line_bits());
    chk("R9 irq low", irq, 0);
    rd_reg(4'd8, v); chk("R10 vector survives reset", v, 16'hA5C3);
    pulse(1, 1, 1, 0, 0);
    rd_reg(4'd9, v); chk("R9 events ignored", v, 16'h0032 | line_bits());
    wr_reg(4'd5, 16'h0003);
    chk("R9 no launch in reset", got_rx_start, 0);
    wr_reg(4'd9, 16'h0041);
    rd_reg(4'd9, v); chk("R9 release ignores other bits", v, 16'h0030 | line_bits());
    chk("R9 dev_reset released", dev_reset, 0);
    wr_reg(4'd9, 16'h0041);
    rd_reg(4'd9, v); chk("R9 normal write after release", v, 16'h0071 | line_bits());

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule